// File: doc/BRIEF.md
# Smart Card Clock Divider

This block produces the clock sent to a smart card. A reference clock `clk_i` drives all of its logic, and the output is built from flip-flop state only. The notional input clock that the card clock is divided from runs at 1/2^(BASE_LOG2+1) of `clk_i`. The card clock equals that input clock divided by 1, 2, 4 or 8. In the default configuration (BASE_LOG2 = 1) a divide-by-1 output has a period of 4 reference cycles, and a divide-by-8 output has a period of 32.

Software can change the ratio and the run/stop mode at any moment during a card session. The block defers each change to a point where the change cannot cut a pulse short. A ratio change waits for an instant where both the old and the new divided clocks begin a low phase. A stop or a restart waits for the next edge of the active divided clock in the required direction. While the power sequencer holds the card disabled, the output parks low.

Top module: `sc_clkdiv`

## Requirements
- R1: `ratio_i` = r (0..3) selects division by 2^r. In steady running the output is high for exactly 2^(BASE_LOG2+r) reference cycles and low for the same count, which gives an exact 50% duty cycle.
- R2: While `rst_ni` is low, `card_clk_o` is low. After release the active ratio is divide-by-1 and the mode is run, whatever `ratio_i` holds, so the first high phase lasts 2^BASE_LOG2 cycles.
- R3: `mode_i` codes are 2'b00 run, 2'b01 stop low and 2'b10 stop high. A stop takes effect at the first edge of the active divided clock toward the requested level. That edge comes within 2 + 2^(BASE_LOG2+r) cycles of the code being applied. The level then holds for as long as the stop lasts.
- R4: Code 2'b11 is reserved. Applying it leaves the previously accepted mode in force, whether that mode is a stop or run.
- R5: No output phase, high or low, is shorter than 2^BASE_LOG2 reference cycles. While running, every high phase has exactly the half-period of one of the ratios.
- R6: A new ratio is adopted only where the counter bits up to the slower of the two taps are all zero. This happens within 2^(BASE_LOG2+RATIO_W+2) cycles, and the output then runs at the new ratio.
- R7: While `card_en_i` is low, the block acts as in stop low whatever the mode. After enable returns, the accepted mode applies again.
- R8: On leaving a stop for run, the first output change happens at an edge of the active divided clock. The first full phase after that change has the full half-period of the ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; clocks all logic |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_i | input | RATIO_W | Requested divide ratio exponent |
| mode_i | input | 2 | Requested run/stop mode |
| card_en_i | input | 1 | Card activated by power sequencer |
| card_clk_o | output | 1 | Clock to the card |

## Verification
A wrong active ratio or a ratio switched at the wrong moment shows at `card_clk_o` in two ways. A high or low phase has the wrong length within one output period, or a phase runs shorter than the minimum half-period at the switching point itself. A mode register that takes in the reserved code, or that misreads a stop, shows as a parked level that moves within one half-period, or as a clock that keeps running when it should hold. A restart that skips the edge rule shows as a shortened first high or low phase straight after the stop ends.

// File: rtl/sc_clk_pkg.sv
package sc_clk_pkg;

  typedef enum logic [1:0] {
    MODE_RUN     = 2'b00,
    MODE_STOP_LO = 2'b01,
    MODE_STOP_HI = 2'b10,
    MODE_RSVD    = 2'b11
  } clk_mode_e;

endpackage

// File: rtl/sc_clk_phase_ctr.sv
// Free-running phase counter; every divided clock is one of its bits.
module sc_clk_phase_ctr #(
  parameter int BASE_LOG2 = 1,
  parameter int NUM_RATIO = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  output logic [NUM_RATIO-1:0]           taps_q_o,
  output logic [NUM_RATIO-1:0]           taps_nxt_o,
  output logic [BASE_LOG2+NUM_RATIO-1:0] zero_pfx_o
);

  localparam int CntW = BASE_LOG2 + NUM_RATIO;

  logic [CntW-1:0] cnt_q;
  logic [CntW-1:0] cnt_nxt;

  assign cnt_nxt = cnt_q + CntW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt;
  end

  for (genvar k = 0; k < NUM_RATIO; k++) begin : g_tap
    assign taps_q_o[k]   = cnt_q[BASE_LOG2+k];
    assign taps_nxt_o[k] = cnt_nxt[BASE_LOG2+k];
  end

  // zero_pfx_o[j]: next count has bits j..0 all clear
  always_comb begin
    logic run_zero;
    run_zero = 1'b1;
    for (int j = 0; j < CntW; j++) begin
      run_zero      = run_zero & ~cnt_nxt[j];
      zero_pfx_o[j] = run_zero;
    end
  end

endmodule

// File: rtl/sc_clk_ratio_sel.sv
// Holds the active ratio; adopts a request only at a shared low-phase start.
module sc_clk_ratio_sel #(
  parameter int RATIO_W   = 2,
  parameter int BASE_LOG2 = 1
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [RATIO_W-1:0]                    ratio_i,
  input  logic [(1<<RATIO_W)-1:0]               taps_q_i,
  input  logic [(1<<RATIO_W)-1:0]               taps_nxt_i,
  input  logic [BASE_LOG2+(1<<RATIO_W)-1:0]     zero_pfx_i,
  output logic                                  tap_q_o,
  output logic                                  tap_nxt_o
);

  localparam int NumRatio = 1 << RATIO_W;
  localparam int CntW     = BASE_LOG2 + NumRatio;
  localparam int IdxW     = (CntW > 1) ? $clog2(CntW) : 1;

  logic [RATIO_W-1:0] act_q;
  logic [RATIO_W-1:0] slow_sel;
  logic [IdxW-1:0]    pfx_idx;
  logic               commit;

  assign slow_sel = (ratio_i > act_q) ? ratio_i : act_q;
  assign pfx_idx  = IdxW'(BASE_LOG2) + IdxW'(slow_sel);
  assign commit   = (ratio_i != act_q) && zero_pfx_i[pfx_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= '0;
    else if (commit) act_q <= ratio_i;
  end

  assign tap_q_o   = taps_q_i[act_q];
  assign tap_nxt_o = taps_nxt_i[act_q];

  // R6: a switch lands where the newly active divided clock is low
  assert_switch_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q != $past(act_q)) |-> !tap_q_o);

  // R6: a switch only ever moves to the ratio that was requested
  assert_switch_target_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q != $past(act_q)) |-> (act_q == $past(ratio_i)));

endmodule

// File: rtl/sc_clk_park_ctl.sv
// Mode register and output flop; the output moves only on an active tap edge.
module sc_clk_park_ctl
  import sc_clk_pkg::*;
#(
  parameter int BASE_LOG2 = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       card_en_i,
  input  logic       tap_q_i,
  input  logic       tap_nxt_i,
  output logic       clk_o
);

  localparam int MinHalf = 1 << BASE_LOG2;
  localparam int LenW    = BASE_LOG2 + 1;

  clk_mode_e mode_req;
  clk_mode_e mode_q;
  clk_mode_e eff_mode;
  logic      out_q;
  logic      out_d;
  logic      rise_ev;
  logic      fall_ev;
  logic [LenW-1:0] len_q;

  assign mode_req = clk_mode_e'(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     mode_q <= MODE_RUN;
    else if (mode_req != MODE_RSVD)  mode_q <= mode_req;
  end

  assign eff_mode = card_en_i ? mode_q : MODE_STOP_LO;
  assign rise_ev  = !tap_q_i &&  tap_nxt_i;
  assign fall_ev  =  tap_q_i && !tap_nxt_i;

  always_comb begin
    out_d = out_q;
    case (eff_mode)
      MODE_RUN: begin
        if (out_q && fall_ev)       out_d = 1'b0;
        else if (!out_q && rise_ev) out_d = 1'b1;
      end
      MODE_STOP_LO: if (out_q && fall_ev)  out_d = 1'b0;
      MODE_STOP_HI: if (!out_q && rise_ev) out_d = 1'b1;
      default:      out_d = out_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= out_d;
  end

  assign clk_o = out_q;

  // stable-cycle count of the current phase, saturating at MinHalf-1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          len_q <= '0;
    else if (out_d != out_q)              len_q <= '0;
    else if (len_q != LenW'(MinHalf - 1)) len_q <= len_q + LenW'(1);
  end

  assert_min_phase_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_q != $past(out_q)) |-> ($past(len_q) == LenW'(MinHalf - 1)));

  assert_park_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!card_en_i && !out_q) |=> !out_q);

  assert_stop_lo_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_en_i && mode_q == MODE_STOP_LO && !out_q) |=> !out_q);

  assert_stop_hi_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_en_i && mode_q == MODE_STOP_HI && out_q) |=> out_q);

endmodule

// File: rtl/sc_clkdiv.sv
module sc_clkdiv #(
  parameter int RATIO_W   = 2,
  parameter int BASE_LOG2 = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [1:0]         mode_i,
  input  logic               card_en_i,
  output logic               card_clk_o
);

  localparam int NumRatio = 1 << RATIO_W;
  localparam int CntW     = BASE_LOG2 + NumRatio;

  logic [NumRatio-1:0] taps_q;
  logic [NumRatio-1:0] taps_nxt;
  logic [CntW-1:0]     zero_pfx;
  logic                tap_q;
  logic                tap_nxt;

  sc_clk_phase_ctr #(
    .BASE_LOG2 (BASE_LOG2),
    .NUM_RATIO (NumRatio)
  ) u_phase_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .taps_q_o   (taps_q),
    .taps_nxt_o (taps_nxt),
    .zero_pfx_o (zero_pfx)
  );

  sc_clk_ratio_sel #(
    .RATIO_W   (RATIO_W),
    .BASE_LOG2 (BASE_LOG2)
  ) u_ratio_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ratio_i    (ratio_i),
    .taps_q_i   (taps_q),
    .taps_nxt_i (taps_nxt),
    .zero_pfx_i (zero_pfx),
    .tap_q_o    (tap_q),
    .tap_nxt_o  (tap_nxt)
  );

  sc_clk_park_ctl #(
    .BASE_LOG2 (BASE_LOG2)
  ) u_park_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .card_en_i (card_en_i),
    .tap_q_i   (tap_q),
    .tap_nxt_i (tap_nxt),
    .clk_o     (card_clk_o)
  );

endmodule

// File: tb/sc_clkdiv_bench.sv
module sc_clkdiv_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RW         = 2;
  localparam int BL         = 1;
  localparam int HB         = 1 << BL;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [RW-1:0] ratio = '0;
  logic [1:0]    mode = 2'b00;
  logic          card_en = 1'b1;
  logic          card_clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit mon_run = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_clkdiv #(.RATIO_W(RW), .BASE_LOG2(BL)) u_sc_clkdiv (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ratio_i    (ratio),
    .mode_i     (mode),
    .card_en_i  (card_en),
    .card_clk_o (card_clk)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(output int hi, output int lo);
    hi = 0; lo = 0;
    while (card_clk !== 1'b0) @(negedge clk);
    while (card_clk !== 1'b1) @(negedge clk);
    while (card_clk === 1'b1) begin hi++; @(negedge clk); end
    while (card_clk === 1'b0) begin lo++; @(negedge clk); end
  endtask

  task automatic wait_level(input logic lvl, input int bound, output bit hit);
    hit = 1'b0;
    for (int i = 0; i <= bound; i++) begin
      if (card_clk === lvl) begin hit = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic hold_level(input logic lvl, input int n, input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      if (card_clk !== lvl) bad++;
      @(negedge clk);
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic first_high(input int bound, output int hi);
    bit hit;
    hi = 0;
    wait_level(1'b1, bound, hit);
    if (hit) while (card_clk === 1'b1) begin hi++; @(negedge clk); end
  endtask

  // phase monitor: minimum length always, exact high lengths while running
  int   ph_len = 0;
  logic ph_lvl = 1'b0;
  bit   ph_seen = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      ph_len = 0; ph_lvl = 1'b0; ph_seen = 1'b0;
    end else if (card_clk !== ph_lvl) begin
      if (ph_seen) begin
        chk(ph_len >= HB, "R5 min phase", ph_len, HB);
        if (mon_run && ph_lvl === 1'b1)
          chk(ph_len == HB || ph_len == 2*HB || ph_len == 4*HB || ph_len == 8*HB,
              "R5 run high phase", ph_len, HB);
      end
      ph_seen = 1'b1;
      ph_lvl  = card_clk;
      ph_len  = 1;
    end else begin
      ph_len++;
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    int hi, lo, half;
    bit hit;

    // R2: reset state, then default ratio 1/1 despite a pending request of 3
    ratio = 2'd3;
    step(5);
    chk(card_clk === 1'b0, "R2 low in reset", int'(card_clk), 0);
    rst_n = 1'b1;
    first_high(10, hi);
    chk(hi == HB, "R2 first high at 1/1", hi, HB);
    step(40);
    measure(hi, lo);
    chk(hi == 8*HB && lo == 8*HB, "R2 then R6 adopt ratio 3", hi, 8*HB);

    // R1: steady periods for every ratio
    mon_run = 1'b1;
    for (int r = 0; r < 4; r++) begin
      ratio = RW'(r);
      step(40);
      measure(hi, lo);
      chk(hi == (HB << r), "R1 high length", hi, HB << r);
      chk(lo == (HB << r), "R1 low length", lo, HB << r);
    end

    // R6/R5: every ratio pair at several offsets
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int off = 0; off < 6; off++) begin
          ratio = RW'(a);
          step(40 + off);
          ratio = RW'(b);
          step(40);
          measure(hi, lo);
          chk(hi == (HB << b) && lo == (HB << b), "R6 switched period", hi, HB << b);
        end
    mon_run = 1'b0;

    // R3/R4/R8: stops, reserved code, resume
    for (int r = 0; r < 4; r++) begin
      half = HB << r;
      ratio = RW'(r);
      mode = 2'b00;
      step(40);
      mode = 2'b01;
      wait_level(1'b0, 2 + half, hit);
      chk(hit, "R3 stop low reached", int'(card_clk), 0);
      hold_level(1'b0, 40, "R3 stop low held");
      mode = 2'b11;
      hold_level(1'b0, 40, "R4 reserved keeps stop low");
      mode = 2'b00;
      first_high(2 + 2*half, hi);
      chk(hi == half, "R8 first high after stop low", hi, half);
      mode = 2'b10;
      wait_level(1'b1, 2 + half, hit);
      chk(hit, "R3 stop high reached", int'(card_clk), 1);
      hold_level(1'b1, 40, "R3 stop high held");
      mode = 2'b11;
      hold_level(1'b1, 40, "R4 reserved keeps stop high");
      mode = 2'b00;
      measure(hi, lo);
      chk(hi == half && lo == half, "R8 period after stop high", hi, half);
      mode = 2'b11;
      step(3);
      measure(hi, lo);
      chk(hi == half && lo == half, "R4 reserved keeps run", hi, half);
      mode = 2'b00;
    end

    // R7: card disable forces low and overrides stop high
    half = HB << 2;
    ratio = 2'd2;
    step(40);
    mode = 2'b10;
    card_en = 1'b0;
    wait_level(1'b0, 2 + half, hit);
    chk(hit, "R7 low after disable", int'(card_clk), 0);
    hold_level(1'b0, 60, "R7 held low while disabled");
    card_en = 1'b1;
    wait_level(1'b1, 2 + 2*half, hit);
    chk(hit, "R7 mode restored after enable", int'(card_clk), 1);
    hold_level(1'b1, 20, "R7 stop high after enable");
    mode = 2'b00;
    measure(hi, lo);
    chk(hi == half && lo == half, "R7 run after enable", hi, half);

    finish_run();
  end

endmodule